// File: doc/BRIEF.md
# Display Mode Register File

This block is the programming interface of a linear framebuffer display controller. Software writes the resolution, colour depth, line pitch in pixels, pan position and an enable bit into a bank of 16-bit registers through a simple write-strobe bus. It reads back those values, a fixed identity code and the video memory size through the same bus. A separate 32-bit register selects the framebuffer byte order. Only two magic words change it.

From the stored registers the block works out the active mode in combinational logic: bytes per pixel, line stride, frame size and the byte offset of the first visible pixel. A mode-valid flag is raised only when the mode is enabled, has a supported depth, is at least 64 by 64 pixels, and lies entirely inside video memory. The scan-out engine downstream uses these outputs directly.

Top module: `vmode_regfile`

## Requirements
- R1: A bus access at byte address A selects register index A>>1, so the two byte addresses of a pair alias. Writable indices are 1 (width), 2 (height), 3 (depth), 4 (control), 5 (virtual width), 6 (X pan) and 7 (Y pan). A write stores wdata_i[15:0] at the next clock edge, and a read returns the stored value zero-extended to 32 bits.
- R2: A read of index 0 returns 16'h0A25, zero-extended, whatever was written there.
- R3: A read of index 8 returns VRAM_BYTES / 65536, zero-extended. Writes there have no effect.
- R4: A read of any index from 9 upward returns 32'h0000_FFFF, unless the address is the byte-order address. A write at such an index changes no register and no output.
- R5: mode_valid_o is high only when bit 0 of the control register is set.
- R6: A depth of 16 gives bpp_o = 2 and a depth of 32 gives bpp_o = 4. Any other depth gives bpp_o = 0 and the mode is invalid.
- R7: The effective line width is the larger of the virtual width and the width. stride_o is that width times bpp_o.
- R8: size_o equals stride_o times the height. offset_o equals X pan times bpp_o plus Y pan times stride_o. Both are computed without overflow for every 16-bit input.
- R9: The mode is invalid when the width or the height is below 64.
- R10: The mode is invalid when offset_o + size_o exceeds VRAM_BYTES. A frame that ends exactly at VRAM_BYTES is valid.
- R11: A 32-bit write to byte address 8'h40 of 32'h4249_4745 selects big-endian and of 32'h4C49_5445 selects little-endian. Any other value leaves the setting unchanged. A read there returns the word for the current order, and big_endian_o shows it.
- R12: Reset clears every writable register and selects little-endian, so the mode is invalid with bpp_o, stride_o, size_o and offset_o all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| bpp_o | output | 3 | Bytes per pixel (0, 2 or 4) |
| stride_o | output | 18 | Line stride in bytes |
| size_o | output | 34 | Frame size in bytes |
| offset_o | output | 35 | Byte offset of the first visible pixel |
| big_endian_o | output | 1 | Framebuffer byte order is big-endian |
| mode_valid_o | output | 1 | Derived mode is usable |

## Verification
The bench targets the fit boundary. It tests a frame that ends exactly at the top of video memory and the same frame panned four bytes further. A design that used a strict compare, or that truncated the sum, would drop the first case or accept the second. It also programs 65535-sized width, height and pan values, where a narrow multiplier would wrap and report a huge mode as fitting. Other targets are width and height at 63 and 64, and a virtual width both below and above the width, where a missing clamp gives a short stride. A write sweep over every address checks odd-byte aliasing and ignored out-of-range writes. Near-miss byte-order words are written as well, and a decoder that tested only some bits would flip the order on them.

// File: rtl/vmode_pkg.sv
package vmode_pkg;
  localparam int REG_W    = 16;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 9;
  localparam int SEL_W    = $clog2(NUM_REGS);

  localparam int IDX_ID     = 0;
  localparam int IDX_XRES   = 1;
  localparam int IDX_YRES   = 2;
  localparam int IDX_DEPTH  = 3;
  localparam int IDX_CTRL   = 4;
  localparam int IDX_VWIDTH = 5;
  localparam int IDX_XOFF   = 6;
  localparam int IDX_YOFF   = 7;
  localparam int IDX_MEMSZ  = 8;

  localparam logic [REG_W-1:0]  ID_VALUE     = 16'h0A25;
  localparam int                ORDER_ADDR   = 'h40;
  localparam logic [DATA_W-1:0] ORDER_BIG    = 32'h4249_4745;
  localparam logic [DATA_W-1:0] ORDER_LITTLE = 32'h4C49_5445;
  localparam int                MIN_DIM      = 64;

  localparam int STRIDE_W = REG_W + 2;
  localparam int FRAME_W  = STRIDE_W + REG_W;
  localparam int OFFS_W   = FRAME_W + 1;
  localparam int SUM_W    = OFFS_W + 1;

  typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_file_t;
endpackage

// File: rtl/vmode_regbank.sv
module vmode_regbank
  import vmode_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output reg_file_t         regs_o,
  output logic              big_endian_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             order_sel;
  assign idx       = addr_i[ADDR_W-1:1];
  assign order_sel = (addr_i == ADDR_W'(ORDER_ADDR));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == IDX_ID || i == IDX_MEMSZ) begin : g_ro
      assign regs_o[i] = '0;
    end else begin : g_rw
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && !order_sel && idx == IDX_W'(i)) q <= wdata_i[REG_W-1:0];
      end
      assign regs_o[i] = q;
    end
  end

  logic big_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) big_q <= 1'b0;
    else if (we_i && order_sel) begin
      if (wdata_i == ORDER_BIG)         big_q <= 1'b1;
      else if (wdata_i == ORDER_LITTLE) big_q <= 1'b0;
    end
  end
  assign big_endian_o = big_q;

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_o)); // R4

  AST_ORDER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && order_sel && (wdata_i == ORDER_BIG || wdata_i == ORDER_LITTLE))
      |=> $stable(big_endian_o)); // R11

  AST_ORDER_BIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && order_sel && wdata_i == ORDER_BIG) |=> big_endian_o); // R11
endmodule

// File: rtl/vmode_calc.sv
module vmode_calc
  import vmode_pkg::*;
#(
  parameter longint unsigned VRAM_BYTES = 64'd16777216
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [REG_W-1:0]    xres_i,
  input  logic [REG_W-1:0]    yres_i,
  input  logic [REG_W-1:0]    depth_i,
  input  logic [REG_W-1:0]    vwidth_i,
  input  logic [REG_W-1:0]    xoff_i,
  input  logic [REG_W-1:0]    yoff_i,
  input  logic                en_i,
  output logic [2:0]          bpp_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [FRAME_W-1:0]  size_o,
  output logic [OFFS_W-1:0]   offset_o,
  output logic                valid_o
);
  localparam logic [SUM_W-1:0] VRAM_LIM = SUM_W'(VRAM_BYTES);

  logic                depth_ok;
  logic [REG_W-1:0]    eff_w;
  logic [STRIDE_W-1:0] xbytes;
  logic [FRAME_W-1:0]  ybytes;
  logic [SUM_W-1:0]    end_addr;
  logic                dims_ok;

  always_comb begin
    unique case (depth_i)
      16'd16:  bpp_o = 3'd2;
      16'd32:  bpp_o = 3'd4;
      default: bpp_o = 3'd0;
    endcase
    depth_ok = (bpp_o != 3'd0);
  end

  // clamp pitch to the visible width
  assign eff_w = (vwidth_i < xres_i) ? xres_i : vwidth_i;

  always_comb begin
    unique case (bpp_o)
      3'd2:    begin stride_o = STRIDE_W'(eff_w) << 1; xbytes = STRIDE_W'(xoff_i) << 1; end
      3'd4:    begin stride_o = STRIDE_W'(eff_w) << 2; xbytes = STRIDE_W'(xoff_i) << 2; end
      default: begin stride_o = '0;                    xbytes = '0;                    end
    endcase
  end

  assign size_o   = FRAME_W'(stride_o) * FRAME_W'(yres_i);
  assign ybytes   = FRAME_W'(stride_o) * FRAME_W'(yoff_i);
  assign offset_o = OFFS_W'(xbytes) + OFFS_W'(ybytes);
  assign end_addr = SUM_W'(offset_o) + SUM_W'(size_o);
  assign dims_ok  = (xres_i >= REG_W'(MIN_DIM)) && (yres_i >= REG_W'(MIN_DIM));
  assign valid_o  = en_i && depth_ok && dims_ok && (end_addr <= VRAM_LIM);

  AST_VALID_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> en_i); // R5

  AST_VALID_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (depth_i == 16'd16 || depth_i == 16'd32)); // R6

  AST_STRIDE_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    STRIDE_W'(stride_o) >= STRIDE_W'(STRIDE_W'(xres_i) * STRIDE_W'(bpp_o))); // R7

  AST_MIN_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (xres_i >= 16'd64 && yres_i >= 16'd64)); // R9

  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (SUM_W'(size_o) <= VRAM_LIM && SUM_W'(offset_o) <= VRAM_LIM)); // R10
endmodule

// File: rtl/vmode_rdmux.sv
module vmode_rdmux
  import vmode_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter longint unsigned VRAM_BYTES = 64'd16777216
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  reg_file_t         regs_i,
  input  logic              big_endian_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int               IDX_W     = ADDR_W - 1;
  localparam logic [REG_W-1:0] MEMSZ_VAL = REG_W'(VRAM_BYTES / 64'd65536);

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:1];

  always_comb begin
    if (addr_i == ADDR_W'(ORDER_ADDR))
      rdata_o = big_endian_i ? ORDER_BIG : ORDER_LITTLE;
    else if (idx == IDX_W'(IDX_ID))
      rdata_o = DATA_W'(ID_VALUE);
    else if (idx == IDX_W'(IDX_MEMSZ))
      rdata_o = DATA_W'(MEMSZ_VAL);
    else if (idx < IDX_W'(NUM_REGS))
      rdata_o = DATA_W'(regs_i[SEL_W'(idx)]);
    else
      rdata_o = DATA_W'({REG_W{1'b1}});
  end
endmodule

// File: rtl/vmode_regfile.sv
module vmode_regfile
  import vmode_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter longint unsigned VRAM_BYTES = 64'd16777216
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2:0]          bpp_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [FRAME_W-1:0]  size_o,
  output logic [OFFS_W-1:0]   offset_o,
  output logic                big_endian_o,
  output logic                mode_valid_o
);
  if (VRAM_BYTES < 64'd4194304 || VRAM_BYTES > 64'd268435456 ||
      (VRAM_BYTES & (VRAM_BYTES - 64'd1)) != 64'd0) begin : g_bad_vram
    $error("VRAM_BYTES must be a power of two from 4 MiB to 256 MiB");
  end

  reg_file_t regs;
  logic      big_endian;

  vmode_regbank #(.ADDR_W(ADDR_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .regs_o       (regs),
    .big_endian_o (big_endian)
  );

  vmode_rdmux #(.ADDR_W(ADDR_W), .VRAM_BYTES(VRAM_BYTES)) u_rdmux (
    .addr_i       (addr_i),
    .regs_i       (regs),
    .big_endian_i (big_endian),
    .rdata_o      (rdata_o)
  );

  vmode_calc #(.VRAM_BYTES(VRAM_BYTES)) u_calc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xres_i   (regs[IDX_XRES]),
    .yres_i   (regs[IDX_YRES]),
    .depth_i  (regs[IDX_DEPTH]),
    .vwidth_i (regs[IDX_VWIDTH]),
    .xoff_i   (regs[IDX_XOFF]),
    .yoff_i   (regs[IDX_YOFF]),
    .en_i     (regs[IDX_CTRL][0]),
    .bpp_o    (bpp_o),
    .stride_o (stride_o),
    .size_o   (size_o),
    .offset_o (offset_o),
    .valid_o  (mode_valid_o)
  );

  assign big_endian_o = big_endian;

  AST_RESET_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !mode_valid_o); // R12
endmodule

// File: tb/sim_vmode_regfile.sv
module sim_vmode_regfile;
  localparam longint VRAM = 64'd16777216;
  localparam logic [31:0] BIG = 32'h4249_4745;
  localparam logic [31:0] LIT = 32'h4C49_5445;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  bpp;
  logic [17:0] stride;
  logic [33:0] size;
  logic [34:0] offset;
  logic        big_endian, mode_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vmode_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .bpp_o(bpp), .stride_o(stride), .size_o(size),
    .offset_o(offset), .big_endian_o(big_endian), .mode_valid_o(mode_valid)
  );

  // behavioural reference state
  longint mreg[9];
  bit     mbig;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) mreg[i] = 0;
      mbig = 0;
    end else if (we) begin
      if (addr == 8'h40) begin
        if (wdata == BIG) mbig = 1;
        else if (wdata == LIT) mbig = 0;
      end else begin
        int k;
        k = int'(addr) / 2;
        if (k >= 1 && k <= 7) mreg[k] = longint'(wdata & 32'hFFFF);
      end
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%0h act=%0d exp=%0d at %0t", tag, addr, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      longint eb, ew, es, esz, eo, erd;
      bit ev;
      int k;
      string rtag;
      eb = (mreg[3] == 16) ? 2 : (mreg[3] == 32) ? 4 : 0;
      ew = (mreg[5] < mreg[1]) ? mreg[1] : mreg[5];
      es = ew * eb;
      esz = es * mreg[2];
      eo = mreg[6] * eb + mreg[7] * es;
      ev = mreg[4][0] && eb != 0 && mreg[1] >= 64 && mreg[2] >= 64 && (eo + esz) <= VRAM;
      k = int'(addr) / 2;
      if (addr == 8'h40) begin erd = mbig ? longint'(BIG) : longint'(LIT); rtag = "R11"; end
      else if (k == 0)   begin erd = 16'h0A25; rtag = "R2"; end
      else if (k == 8)   begin erd = VRAM / 65536; rtag = "R3"; end
      else if (k < 9)    begin erd = mreg[k]; rtag = "R1"; end
      else               begin erd = 16'hFFFF; rtag = "R4"; end
      if (!rst_n) begin
        check("R12 valid", longint'(mode_valid), 0);
        check("R12 bpp", longint'(bpp), 0);
        check("R12 stride", longint'(stride), 0);
        check("R12 order", longint'(big_endian), 0);
      end else begin
        check(rtag, longint'(rdata), erd);
        check("R5 R9 R10 valid", longint'(mode_valid), longint'(ev));
        check("R6 bpp", longint'(bpp), eb);
        check("R7 stride", longint'(stride), es);
        check("R8 size", longint'(size), esz);
        check("R8 offset", longint'(offset), eo);
        check("R11 order", longint'(big_endian), longint'(mbig));
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(posedge clk); #2;
    we = 1'b0; addr = a;
  endtask

  task automatic mode(int xr, int yr, int dp, int vw, int xo, int yo, int en);
    wr(8'h02, 32'(xr)); wr(8'h04, 32'(yr)); wr(8'h06, 32'(dp));
    wr(8'h0A, 32'(vw)); wr(8'h0C, 32'(xo)); wr(8'h0E, 32'(yo));
    wr(8'h08, 32'(en)); rd(8'h08); rd(8'h02);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R2 R3 R4 constant reads and ignored writes
    rd(8'h00); rd(8'h01); rd(8'h10); rd(8'h12); rd(8'hFE);
    wr(8'h00, 32'h1234); rd(8'h00);
    wr(8'h10, 32'h0001); rd(8'h10);
    wr(8'h14, 32'hBEEF); wr(8'h30, 32'h7777); rd(8'h14);
    // R5 R6 R8 basic modes
    mode(640, 480, 32, 0, 0, 0, 1);
    mode(640, 480, 16, 0, 0, 0, 1);
    mode(640, 480, 24, 0, 0, 0, 1);
    mode(640, 480, 8, 0, 0, 0, 1);
    mode(640, 480, 32, 0, 0, 0, 0);
    mode(640, 480, 32, 0, 0, 0, 2);
    // R7 virtual width clamp
    mode(640, 480, 32, 1024, 0, 0, 1);
    mode(640, 480, 16, 320, 0, 0, 1);
    // R8 pan offsets
    mode(640, 480, 32, 800, 3, 5, 1);
    mode(640, 480, 16, 0, 17, 9, 1);
    // R9 minimum size
    mode(63, 480, 32, 0, 0, 0, 1);
    mode(64, 64, 32, 0, 0, 0, 1);
    mode(640, 63, 32, 0, 0, 0, 1);
    // R10 exact fit and one step over
    mode(4096, 1024, 32, 0, 0, 0, 1);
    mode(4096, 1024, 32, 0, 1, 0, 1);
    mode(4096, 1023, 32, 0, 0, 1, 1);
    mode(4096, 1023, 32, 0, 1, 1, 1);
    mode(65535, 65535, 32, 0, 65535, 65535, 1);
    mode(65535, 64, 16, 65535, 0, 0, 1);
    // R11 byte order
    rd(8'h40);
    wr(8'h40, BIG); rd(8'h40);
    wr(8'h40, 32'h4249_4744); rd(8'h40);
    wr(8'h40, 32'h0000_0000); rd(8'h40);
    wr(8'h40, LIT); rd(8'h40);
    wr(8'h40, 32'hC249_4745); rd(8'h40);
    wr(8'h41, BIG); rd(8'h40); rd(8'h41);
    // R1 R4 write sweep over all addresses, then read back
    for (int a = 0; a < 256; a++)
      if (a != 8'h40) wr(8'(a), 32'(a * 257 + 32'h00AB_0000));
    for (int a = 0; a < 256; a++) rd(8'(a));
    mode(800, 600, 32, 0, 0, 0, 1);
    wr(8'h40, BIG);
    // R12 reset in mid-run
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(8'h02); rd(8'h08); rd(8'h40); rd(8'h06);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end
endmodule